// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the five interrupt causes of a buffered UART into one 32-bit status word and one level interrupt line. The causes are a line-status event, receive data available, receive character timeout, transmit space available and a modem-line change. Each cause is gated by an enable bit. Once a cause is latched, its identification bit stays set until the host writes a one to that bit. Several identification bits may be set together. The FIFOs and the serializer sit outside the block: they deliver one-cycle event pulses and present the receive fill count and the line-status flags as levels.

The same status word carries more than the identification bits. It shows the synchronized modem input levels, sticky change flags for each modem line, the line-status flags, and the 10-bit receive fill count. The high two bits of the fill count share the low byte with the identification bits. For that reason the clear write is a byte write, and its bits 7:5 are ignored. The four modem inputs are asynchronous and are synchronized inside the block.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake. A clear write is a single-cycle strobe that is always accepted.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is applied, and on the first cycle after it, the identification bits (status 4:0), the modem change flags (status 11:8) and `irq` are all zero.
- R2: A cause pulse sets its identification bit on the next clock edge, but only if its enable is set. The mapping is: `ev_line_err` sets bit 0 under `cfg_en[2]`; `ev_rx_data` sets bit 1 under `cfg_en[0]`; `ev_rx_timeout` sets bit 2 under `cfg_en[0]`; `ev_tx_space` sets bit 3 under `cfg_en[1]`. A pulse whose enable is clear leaves its bit at zero.
- R3: Any combination of identification bits can be set at the same time, and each bit is independent of the others.
- R4: A cycle with `clr_wr` high clears exactly those identification bits whose `clr_byte` bit (4:0) is one. If a bit's cause arrives in the same cycle as its clear, the bit stays set. `clr_byte` bits 7:5 have no effect.
- R5: Status bits 7:6 show `rx_count[9:8]` and bits 31:24 show `rx_count[7:0]`. Bit 5 reads zero. Clear writes do not alter these fields.
- R6: Status bits 23:16 mirror `line_status[7:0]` bit for bit.
- R7: Status bits 15:12 show the synchronized levels of `modem_async[3:0]`. The order is CTS, DSR, RI, DCD, with CTS at bit 12. A level appears two edges after the input changes. Each change flag (bits 11:8, same order) sets on either edge of its line, three edges after the input changes.
- R8: A modem-line change sets identification bit 4 at the same edge as the change flag, if `cfg_en[3]` is set. A clear write with `clr_byte[4]` high clears bit 4 and all four change flags. A clear write without bit 4 leaves the change flags set.
- R9: `irq` is high exactly when at least one identification bit is set. Clearing enable bits does not drop identification bits that are already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 4 | Enables: 0 receive, 1 transmit space, 2 line status, 3 modem |
| ev_line_err | input | 1 | Line-status event pulse |
| ev_rx_data | input | 1 | Receive data available pulse |
| ev_rx_timeout | input | 1 | Receive character timeout pulse |
| ev_tx_space | input | 1 | Transmit space available pulse |
| modem_async | input | 4 | Asynchronous modem inputs: 0 CTS, 1 DSR, 2 RI, 3 DCD |
| line_status | input | 8 | Line-status flags from the receiver and transmitter |
| rx_count | input | 10 | Receive FIFO fill count |
| clr_wr | input | 1 | Clear-write strobe for the low status byte |
| clr_byte | input | 8 | Write-one-to-clear mask; bits 4:0 are used |
| status_word | output | 32 | Packed status word |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check that each identification bit rises only after its cause has been seen while enabled. They also check that a clear with no competing cause removes the bit, that a change flag stays set until a modem clear, and that the interrupt line drops only after a clear write. The following can only be shown by the bench's scenarios: the full mapping of causes to bits under every enable setting, the set-over-clear collision, the synchronizer latency of the modem levels and change flags, the packing of the fill count and line-status fields, and the retention of bits after their enables are withdrawn.

// File: rtl/uart_irq_ident_pkg.sv
package uart_irq_ident_pkg;
  localparam int ID_W       = 5;
  localparam int ID_LINE    = 0;
  localparam int ID_RXDATA  = 1;
  localparam int ID_RXTMO   = 2;
  localparam int ID_TXSPACE = 3;
  localparam int ID_MODEM   = 4;

  localparam int EN_W      = 4;
  localparam int EN_RX     = 0;
  localparam int EN_TX     = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;

  localparam int MODEM_LINES = 4;
  localparam int WORD_W      = 32;

  typedef struct packed {
    logic line_err;
    logic rx_data;
    logic rx_tmo;
    logic tx_space;
    logic modem_chg;
  } cause_t;
endpackage

// File: rtl/uart_irq_modem_sync.sv
module uart_irq_modem_sync #(
  parameter int LINES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_async,
  input  logic             clr_flags,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] chg_flag,
  output logic             chg_any
);
  logic [LINES-1:0] edge_now;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], lines_async[g]};
        prev <= sh[STAGES-1];
      end
    end

    assign level[g]    = sh[STAGES-1];
    assign edge_now[g] = sh[STAGES-1] ^ prev;

    // A new edge in the clearing cycle keeps the flag set.
    always_ff @(posedge clk) begin
      if (!rst_n) chg_flag[g] <= 1'b0;
      else        chg_flag[g] <= (chg_flag[g] & ~clr_flags) | edge_now[g];
    end
  end

  assign chg_any = |edge_now;
endmodule

// File: rtl/uart_irq_id_flags.sv
module uart_irq_id_flags
  import uart_irq_ident_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] en,
  input  cause_t          cause,
  input  logic            clr_wr,
  input  logic [ID_W-1:0] clr_mask,
  output logic [ID_W-1:0] id,
  output logic            irq
);
  logic [ID_W-1:0] set_vec;
  logic [ID_W-1:0] clr_vec;

  always_comb begin
    set_vec             = '0;
    set_vec[ID_LINE]    = cause.line_err  & en[EN_LINE];
    set_vec[ID_RXDATA]  = cause.rx_data   & en[EN_RX];
    set_vec[ID_RXTMO]   = cause.rx_tmo    & en[EN_RX];
    set_vec[ID_TXSPACE] = cause.tx_space  & en[EN_TX];
    set_vec[ID_MODEM]   = cause.modem_chg & en[EN_MODEM];
    clr_vec             = clr_wr ? clr_mask : '0;
  end

  // A set in the same cycle as a clear takes precedence.
  always_ff @(posedge clk) begin
    if (!rst_n) id <= '0;
    else        id <= (id & ~clr_vec) | set_vec;
  end

  assign irq = |id;
endmodule

// File: rtl/uart_irq_status_pack.sv
module uart_irq_status_pack
  import uart_irq_ident_pkg::*;
#(
  parameter int RXCNT_W = 10
) (
  input  logic [ID_W-1:0]        id,
  input  logic [MODEM_LINES-1:0] modem_level,
  input  logic [MODEM_LINES-1:0] modem_chg,
  input  logic [7:0]             line_status,
  input  logic [RXCNT_W-1:0]     rx_count,
  output logic [WORD_W-1:0]      word
);
  localparam int HI_W = RXCNT_W - 8;

  always_comb begin
    word        = '0;
    word[4:0]   = id;
    word[5]     = 1'b0;
    word[6 +: HI_W] = rx_count[RXCNT_W-1:8];
    word[11:8]  = modem_chg;
    word[15:12] = modem_level;
    word[23:16] = line_status;
    word[31:24] = rx_count[7:0];
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_ident_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RXCNT_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_en,
  input  logic              ev_line_err,
  input  logic              ev_rx_data,
  input  logic              ev_rx_timeout,
  input  logic              ev_tx_space,
  input  logic [3:0]        modem_async,
  input  logic [7:0]        line_status,
  input  logic [9:0]        rx_count,
  input  logic              clr_wr,
  input  logic [7:0]        clr_byte,
  output logic [31:0]       status_word,
  output logic              irq
);
  logic [MODEM_LINES-1:0] m_level;
  logic [MODEM_LINES-1:0] m_chg;
  logic                   m_edge;
  logic [ID_W-1:0]        id;
  cause_t                 cause;

  assign cause = '{line_err:  ev_line_err,
                   rx_data:   ev_rx_data,
                   rx_tmo:    ev_rx_timeout,
                   tx_space:  ev_tx_space,
                   modem_chg: m_edge};

  uart_irq_modem_sync #(
    .LINES  (MODEM_LINES),
    .STAGES (SYNC_STAGES)
  ) modem_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lines_async (modem_async),
    .clr_flags   (clr_wr & clr_byte[ID_MODEM]),
    .level       (m_level),
    .chg_flag    (m_chg),
    .chg_any     (m_edge)
  );

  uart_irq_id_flags flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .cause    (cause),
    .clr_wr   (clr_wr),
    .clr_mask (clr_byte[ID_W-1:0]),
    .id       (id),
    .irq      (irq)
  );

  uart_irq_status_pack #(
    .RXCNT_W (RXCNT_W)
  ) pack_i (
    .id          (id),
    .modem_level (m_level),
    .modem_chg   (m_chg),
    .line_status (line_status),
    .rx_count    (rx_count),
    .word        (status_word)
  );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cfg_en,
  input logic        ev_line_err,
  input logic        ev_rx_data,
  input logic        ev_tx_space,
  input logic        clr_wr,
  input logic [7:0]  clr_byte,
  input logic [31:0] status_word,
  input logic        irq
);
  a_r2_line_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[0]) |-> $past(ev_line_err && cfg_en[2]));

  a_r2_rx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[1]) |-> $past(ev_rx_data && cfg_en[0]));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_byte[3] && !(ev_tx_space && cfg_en[1])) |=> !status_word[3]);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[8] && !(clr_wr && clr_byte[4])) |=> status_word[8]);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_wr));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .ev_line_err (ev_line_err),
  .ev_rx_data  (ev_rx_data),
  .ev_tx_space (ev_tx_space),
  .clr_wr      (clr_wr),
  .clr_byte    (clr_byte),
  .status_word (status_word),
  .irq         (irq)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_en = '0;
  logic        ev_line_err = 1'b0;
  logic        ev_rx_data = 1'b0;
  logic        ev_rx_timeout = 1'b0;
  logic        ev_tx_space = 1'b0;
  logic [3:0]  modem_async = '0;
  logic [7:0]  line_status = '0;
  logic [9:0]  rx_count = '0;
  logic        clr_wr = 1'b0;
  logic [7:0]  clr_byte = '0;
  logic [31:0] status_word;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .ev_line_err(ev_line_err), .ev_rx_data(ev_rx_data),
    .ev_rx_timeout(ev_rx_timeout), .ev_tx_space(ev_tx_space),
    .modem_async(modem_async), .line_status(line_status),
    .rx_count(rx_count), .clr_wr(clr_wr), .clr_byte(clr_byte),
    .status_word(status_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] ev);
    {ev_tx_space, ev_rx_timeout, ev_rx_data, ev_line_err} = ev;
    tick();
    {ev_tx_space, ev_rx_timeout, ev_rx_data, ev_line_err} = '0;
  endtask

  task automatic clear(input logic [7:0] m);
    clr_wr = 1'b1; clr_byte = m;
    tick();
    clr_wr = 1'b0; clr_byte = '0;
  endtask

  function automatic logic [4:0] exp_id(input logic [3:0] en, input logic [3:0] ev);
    exp_id = {1'b0, ev[3] & en[1], ev[2] & en[0], ev[1] & en[0], ev[0] & en[2]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog: got %0d expected below 100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    tick();
    // R1: state under reset
    chk("R1 ids in reset", {27'd0, status_word[4:0]}, 32'd0);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", {20'd0, status_word[11:8], 3'd0, status_word[4:0]}, 32'd0);

    // R2 R3 R5 R9: sweep every enable value against every cause combination
    for (int en = 0; en < 16; en++) begin
      for (int ev = 0; ev < 16; ev++) begin
        logic [4:0] e;
        cfg_en = en[3:0];
        rx_count = 10'(en * 67 + ev * 13);
        e = exp_id(en[3:0], ev[3:0]);
        pulse(ev[3:0]);
        chk("R2 R3 id bits", {27'd0, status_word[4:0]}, {27'd0, e});
        chk("R9 irq level", {31'd0, irq}, {31'd0, e != 5'd0});
        clear(8'hFF);
        chk("R4 full clear", {27'd0, status_word[4:0]}, 32'd0);
        chk("R5 count fields", {status_word[31:24], status_word[7:5]},
            {rx_count[7:0], rx_count[9:8], 1'b0});
      end
    end

    // R4: single-bit clears leave the other bits
    cfg_en = 4'hF;
    for (int k = 0; k < 4; k++) begin
      pulse(4'hF);
      clear(8'(1 << k));
      chk("R4 partial clear", {27'd0, status_word[4:0]}, 32'(5'h0F & ~(5'd1 << k)));
      clear(8'hE0);
      chk("R4 upper bits inert", {27'd0, status_word[4:0]}, 32'(5'h0F & ~(5'd1 << k)));
      clear(8'h1F);
    end

    // R4: set wins over clear in the same cycle
    clr_wr = 1'b1; clr_byte = 8'h01; ev_line_err = 1'b1;
    tick();
    clr_wr = 1'b0; clr_byte = '0; ev_line_err = 1'b0;
    chk("R4 set beats clear", {31'd0, status_word[0]}, 32'd1);

    // R9: withdrawing enables keeps set bits
    pulse(4'hA);
    cfg_en = 4'h0;
    tick();
    chk("R9 retained ids", {27'd0, status_word[4:0]}, 32'h0B);
    chk("R9 retained irq", {31'd0, irq}, 32'd1);
    clear(8'h1F);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);

    // R6: line status mirror
    for (int b = 0; b < 8; b++) begin
      line_status = 8'(1 << b) ^ 8'h5A;
      tick();
      chk("R6 line status", {24'd0, status_word[23:16]}, {24'd0, line_status});
    end

    // R7 R8: modem lines, each rising then falling
    for (int i = 0; i < 4; i++) begin
      cfg_en = 4'h8;
      modem_async[i] = 1'b1;
      tick(); tick();
      chk("R7 level after 2 edges", {28'd0, status_word[15:12]}, 32'(4'd1 << i));
      chk("R7 flag not yet", {28'd0, status_word[11:8]}, 32'd0);
      tick();
      chk("R7 flag on rise", {28'd0, status_word[11:8]}, 32'(4'd1 << i));
      chk("R8 modem id enabled", {31'd0, status_word[4]}, 32'd1);
      clear(8'h0F);
      chk("R8 flag kept without bit 4", {28'd0, status_word[11:8]}, 32'(4'd1 << i));
      clear(8'h10);
      chk("R8 modem clear", {27'd0, status_word[11:8], status_word[4]}, 32'd0);
      cfg_en = 4'h7;
      modem_async[i] = 1'b0;
      tick(); tick(); tick();
      chk("R7 flag on fall", {28'd0, status_word[11:8]}, 32'(4'd1 << i));
      chk("R8 modem id gated", {31'd0, status_word[4]}, 32'd0);
      clear(8'h10);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule